// File: doc/BRIEF.md
# Clock Generator Mode Controller

This controller sits beside the analog core of a differential clock generator and decides, from a handful of slow pins, what that core and its output stage should be doing. An active-low power-down pin, an active-low clock-stop pin, a two-bit output mode select and a two-bit multiplier select are synchronized into the clock domain. The controller then places the generator in one of four run states: power-down, normal, clock stop or test. For each state it drives the PLL and divider enables, the output source select, the output disable and the force-low control.

The controller also reports whether the output may be trusted. Each event that disturbs the output loads a settle counter that counts down on a slow timebase tick. These events are waking from power-down, resuming from clock stop, a multiplier change and a mode change. The settled flag rises only when that counter reaches zero and the PLL reports lock. The block also presents the feedback-to-prescaler ratio A/B that belongs to the selected multiplier. The output frequency is then the reference frequency times A divided by B.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: While reset is asserted the run state is power-down (run_state = 0), with force_low = 1, pll_en = 0, div_en = 0 and settled = 0.
- R2: With the synchronized power-down pin low, the run state is power-down whatever the clock-stop pin. In this state pll_en = 0, div_en = 0, out_dis = 0, force_low = 1 and src_sel = 0.
- R3: With power-down high and clock-stop low, the run state is clock stop (run_state = 2). The PLL and divider stay enabled, out_dis = 1, force_low = 0 and src_sel = 0.
- R4: With both pins high and mode 00, the run state is normal (run_state = 1). The outputs are src_sel = 0 (phase aligner), out_dis = 0 and force_low = 0, with the PLL and divider enabled.
- R5: With both pins high and a non-zero mode, the run state is test (run_state = 3). Mode 01 gives src_sel = 1 (raw PLL). Mode 11 gives src_sel = 2 (reference pass-through). Mode 10 gives out_dis = 1 with src_sel = 0.
- R6: The multiplier select {mult1,mult0} gives ratio_a/ratio_b as follows: 00 is 4/1, 10 is 6/1, 11 is 8/1 and 01 is 16/3.
- R7: Leaving power-down loads PWRUP_TICKS into the settle counter. settled stays low until exactly that many ticks have passed and rises on the last one.
- R8: A change of the multiplier select loads MULT_TICKS. A change of the mode select loads MODE_TICKS.
- R9: Resuming from clock stop into normal or test loads RESUME_TICKS.
- R10: An event that arrives while the counter is running leaves the counter at the larger of its remaining count and the event's latency.
- R11: A pin change reaches the run state on the third rising clock edge after it is applied, and not earlier.
- R12: settled is low in power-down, in clock stop, and whenever pll_lock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset, forces power-down |
| pd_n_pin | input | 1 | Asynchronous power-down pin, low = power down |
| stop_n_pin | input | 1 | Asynchronous clock-stop pin, low = stop outputs |
| mode_pin | input | 2 | Asynchronous output mode select {mode1,mode0} |
| mult_pin | input | 2 | Asynchronous multiplier select {mult1,mult0} |
| tick | input | 1 | Timebase tick for the settle counter |
| pll_lock | input | 1 | Lock indication from the PLL |
| pll_en | output | 1 | PLL/VCO enable |
| div_en | output | 1 | Divider network enable |
| src_sel | output | 2 | Output source: 0 aligner, 1 raw PLL, 2 reference |
| out_dis | output | 1 | Output drivers disabled (high impedance) |
| force_low | output | 1 | Both outputs pulled low |
| settled | output | 1 | Output settled and trustworthy |
| run_state | output | 2 | 0 power-down, 1 normal, 2 clock stop, 3 test |
| ratio_a | output | 5 | Feedback factor A |
| ratio_b | output | 2 | Prescaler factor B |

## Verification
A table of pin combinations covers each run state at least once. Power-down is tried with clock-stop both high and low, which shows that power-down wins. Every mode code is applied under test, so the three test sources cannot be confused, and each multiplier code is paired with a different state to show that the ratio does not depend on the run state. Directed sequences count ticks one at a time around each settle latency. Two overlapping events, one with a shorter and one with a longer latency than the count still pending, tell whether the counter keeps the larger value or wrongly reloads. A pin change sampled two and three edges later pins down the synchronizer depth.

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl #(
  parameter int unsigned PWRUP_TICKS  = 300,
  parameter int unsigned MODE_TICKS   = 300,
  parameter int unsigned MULT_TICKS   = 100,
  parameter int unsigned RESUME_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_n_pin,
  input  logic       stop_n_pin,
  input  logic [1:0] mode_pin,
  input  logic [1:0] mult_pin,
  input  logic       tick,
  input  logic       pll_lock,
  output logic       pll_en,
  output logic       div_en,
  output logic [1:0] src_sel,
  output logic       out_dis,
  output logic       force_low,
  output logic       settled,
  output logic [1:0] run_state,
  output logic [4:0] ratio_a,
  output logic [1:0] ratio_b
);

  localparam int unsigned MAX_A = (PWRUP_TICKS > MODE_TICKS) ? PWRUP_TICKS : MODE_TICKS;
  localparam int unsigned MAX_B = (MULT_TICKS > RESUME_TICKS) ? MULT_TICKS : RESUME_TICKS;
  localparam int unsigned MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW = $clog2(MAX_T + 1);

  localparam logic [CW-1:0] K_PWRUP  = CW'(PWRUP_TICKS);
  localparam logic [CW-1:0] K_MODE   = CW'(MODE_TICKS);
  localparam logic [CW-1:0] K_MULT   = CW'(MULT_TICKS);
  localparam logic [CW-1:0] K_RESUME = CW'(RESUME_TICKS);

  typedef enum logic [1:0] {
    ST_PDN  = 2'd0,
    ST_NORM = 2'd1,
    ST_STOP = 2'd2,
    ST_TEST = 2'd3
  } st_t;

  logic [5:0] meta_q, sync_q;
  logic       s_pd, s_stop;
  logic [1:0] s_mode, s_mult;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= {pd_n_pin, stop_n_pin, mode_pin, mult_pin};
      sync_q <= meta_q;
    end
  end

  assign s_pd   = sync_q[5];
  assign s_stop = sync_q[4];
  assign s_mode = sync_q[3:2];
  assign s_mult = sync_q[1:0];

  st_t           state_q, state_d;
  logic [1:0]    mode_q, mult_q;
  logic [CW-1:0] cnt_q, cnt_d, req;

  always_comb begin
    if (!s_pd)              state_d = ST_PDN;
    else if (!s_stop)       state_d = ST_STOP;
    else if (s_mode == 2'b00) state_d = ST_NORM;
    else                    state_d = ST_TEST;
  end

  always_comb begin
    req = '0;
    if (state_q == ST_PDN && state_d != ST_PDN && K_PWRUP > req)
      req = K_PWRUP;
    if (state_q == ST_STOP && (state_d == ST_NORM || state_d == ST_TEST) && K_RESUME > req)
      req = K_RESUME;
    if (s_mode != mode_q && K_MODE > req)
      req = K_MODE;
    if (s_mult != mult_q && K_MULT > req)
      req = K_MULT;

    if (state_d == ST_PDN)
      cnt_d = '0;
    else if (req != '0)
      cnt_d = (req > cnt_q) ? req : cnt_q;
    else if (tick && cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PDN;
      mode_q  <= 2'b00;
      mult_q  <= 2'b00;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= s_mode;
      mult_q  <= s_mult;
      cnt_q   <= cnt_d;
    end
  end

  assign run_state = state_q;
  assign pll_en    = (state_q != ST_PDN);
  assign div_en    = (state_q != ST_PDN);
  assign force_low = (state_q == ST_PDN);
  assign out_dis   = (state_q == ST_STOP) || (state_q == ST_TEST && mode_q == 2'b10);
  assign settled   = (state_q == ST_NORM || state_q == ST_TEST) && cnt_q == '0 && pll_lock;

  always_comb begin
    src_sel = 2'd0;
    if (state_q == ST_TEST) begin
      case (mode_q)
        2'b01:   src_sel = 2'd1;
        2'b11:   src_sel = 2'd2;
        default: src_sel = 2'd0;
      endcase
    end
  end

  always_comb begin
    case (mult_q)
      2'b00:   begin ratio_a = 5'd4;  ratio_b = 2'd1; end
      2'b10:   begin ratio_a = 5'd6;  ratio_b = 2'd1; end
      2'b11:   begin ratio_a = 5'd8;  ratio_b = 2'd1; end
      default: begin ratio_a = 5'd16; ratio_b = 2'd3; end
    endcase
  end

endmodule

// File: rtl/clkgen_mode_ctrl_chk.sv
module clkgen_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pll_lock,
  input logic       pll_en,
  input logic       div_en,
  input logic       out_dis,
  input logic       force_low,
  input logic       settled,
  input logic [1:0] run_state,
  input logic [4:0] ratio_a,
  input logic [1:0] ratio_b
);

  a_r2_pdn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    force_low |-> (!pll_en && !div_en && !out_dis && !settled));

  a_r3_stop_pll_runs: assert property (@(posedge clk) disable iff (!rst_n)
    out_dis |-> (pll_en && div_en && !force_low));

  a_r12_settled_lock: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> (pll_lock && pll_en));

  a_r7_wake_unsettled: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_low) |-> !settled);

  a_r8_ratio_change_unsettled: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_a) |-> !settled);

  a_r9_resume_unsettled: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_state) == 2'd2 && run_state != 2'd2 && !force_low) |-> !settled);

  a_r6_ratio_b3: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_b == 2'd3) |-> (ratio_a == 5'd16));

  a_r6_ratio_b1: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_b == 2'd1) |-> (ratio_a == 5'd4 || ratio_a == 5'd6 || ratio_a == 5'd8));

endmodule

bind clkgen_mode_ctrl clkgen_mode_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pll_lock  (pll_lock),
  .pll_en    (pll_en),
  .div_en    (div_en),
  .out_dis   (out_dis),
  .force_low (force_low),
  .settled   (settled),
  .run_state (run_state),
  .ratio_a   (ratio_a),
  .ratio_b   (ratio_b)
);

// File: tb/clkgen_mode_ctrl_tb.sv
module clkgen_mode_ctrl_tb;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       pd_n = 1'b0, stop_n = 1'b1, tick = 1'b0, lock = 1'b1;
  logic [1:0] mode = 2'b00, mult = 2'b00;
  logic       pll_en, div_en, out_dis, force_low, settled;
  logic [1:0] src_sel, run_state, ratio_b;
  logic [4:0] ratio_a;

  clkgen_mode_ctrl #(.PWRUP_TICKS(12), .MODE_TICKS(9), .MULT_TICKS(5), .RESUME_TICKS(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .pd_n_pin(pd_n), .stop_n_pin(stop_n), .mode_pin(mode),
    .mult_pin(mult), .tick(tick), .pll_lock(lock), .pll_en(pll_en), .div_en(div_en),
    .src_sel(src_sel), .out_dis(out_dis), .force_low(force_low), .settled(settled),
    .run_state(run_state), .ratio_a(ratio_a), .ratio_b(ratio_b));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // {pd, stop, mode, mult, state, pll, dis, low, src, a, b}
  localparam logic [19:0] VEC [9] = '{
    {1'b0, 1'b1, 2'b00, 2'b00, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 5'd4,  2'd1},
    {1'b0, 1'b0, 2'b10, 2'b10, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 5'd6,  2'd1},
    {1'b1, 1'b1, 2'b00, 2'b11, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 5'd8,  2'd1},
    {1'b1, 1'b0, 2'b00, 2'b01, 2'd2, 1'b1, 1'b1, 1'b0, 2'd0, 5'd16, 2'd3},
    {1'b1, 1'b1, 2'b01, 2'b00, 2'd3, 1'b1, 1'b0, 1'b0, 2'd1, 5'd4,  2'd1},
    {1'b1, 1'b1, 2'b11, 2'b10, 2'd3, 1'b1, 1'b0, 1'b0, 2'd2, 5'd6,  2'd1},
    {1'b1, 1'b1, 2'b10, 2'b11, 2'd3, 1'b1, 1'b1, 1'b0, 2'd0, 5'd8,  2'd1},
    {1'b1, 1'b0, 2'b11, 2'b00, 2'd2, 1'b1, 1'b1, 1'b0, 2'd0, 5'd4,  2'd1},
    {1'b0, 1'b1, 2'b01, 2'b01, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 5'd16, 2'd3}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  function automatic string st_tag(input logic [1:0] s);
    case (s)
      2'd0:    return "R2";
      2'd1:    return "R4";
      2'd2:    return "R3";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    cycles(3);
    // R1 reset state
    chk("R1", "run_state", run_state, 0);
    chk("R1", "force_low", force_low, 1);
    chk("R1", "pll_en", pll_en, 0);
    chk("R1", "div_en", div_en, 0);
    chk("R1", "settled", settled, 0);
    rst_n = 1'b1;
    cycles(2);

    foreach (VEC[i]) begin
      logic [19:0] v;
      string t;
      v = VEC[i];
      pd_n = v[19]; stop_n = v[18]; mode = v[17:16]; mult = v[15:14];
      cycles(4);
      t = st_tag(v[13:12]);
      chk(t, "run_state", run_state, v[13:12]);
      chk(t, "pll_en", pll_en, v[11]);
      chk(t, "div_en", div_en, v[11]);
      chk(t, "out_dis", out_dis, v[10]);
      chk(t, "force_low", force_low, v[9]);
      chk(t, "src_sel", src_sel, v[8:7]);
      chk("R6", "ratio_a", ratio_a, v[6:2]);
      chk("R6", "ratio_b", ratio_b, v[1:0]);
    end

    rst_n = 1'b0;
    pd_n = 1'b0; stop_n = 1'b1; mode = 2'b00; mult = 2'b00;
    cycles(2);
    rst_n = 1'b1;
    cycles(4);

    // R11 synchronizer latency
    pd_n = 1'b1;
    cycles(2);
    chk("R11", "force_low after 2 edges", force_low, 1);
    cycles(1);
    chk("R11", "force_low after 3 edges", force_low, 0);

    // R7 wake-up latency
    chk("R7", "run_state", run_state, 1);
    chk("R7", "settled at wake", settled, 0);
    ticks(11);
    chk("R7", "settled after 11 ticks", settled, 0);
    ticks(1);
    chk("R7", "settled after 12 ticks", settled, 1);

    // R8 multiplier change
    mult = 2'b10;
    cycles(4);
    chk("R6", "ratio_a", ratio_a, 6);
    chk("R8", "settled after mult change", settled, 0);
    ticks(4);
    chk("R8", "settled after 4 ticks", settled, 0);
    ticks(1);
    chk("R8", "settled after 5 ticks", settled, 1);

    // R8 mode change
    mode = 2'b01;
    cycles(4);
    chk("R5", "src_sel bypass", src_sel, 1);
    chk("R8", "settled after mode change", settled, 0);
    ticks(8);
    chk("R8", "settled after 8 ticks", settled, 0);
    ticks(1);
    chk("R8", "settled after 9 ticks", settled, 1);

    // R10 shorter event keeps pending count
    mode = 2'b11;
    cycles(4);
    chk("R5", "src_sel reference", src_sel, 2);
    ticks(2);
    mult = 2'b11;
    cycles(4);
    ticks(6);
    chk("R10", "settled 6 ticks after short event", settled, 0);
    ticks(1);
    chk("R10", "settled 7 ticks after short event", settled, 1);

    // R10 longer event replaces pending count
    mult = 2'b00;
    cycles(4);
    ticks(3);
    mode = 2'b01;
    cycles(4);
    ticks(8);
    chk("R10", "settled 8 ticks after long event", settled, 0);
    ticks(1);
    chk("R10", "settled 9 ticks after long event", settled, 1);

    // R9 resume from clock stop
    stop_n = 1'b0;
    cycles(4);
    chk("R3", "run_state", run_state, 2);
    chk("R12", "settled in clock stop", settled, 0);
    stop_n = 1'b1;
    cycles(4);
    chk("R9", "run_state", run_state, 3);
    chk("R9", "settled at resume", settled, 0);
    ticks(2);
    chk("R9", "settled after 2 ticks", settled, 0);
    ticks(1);
    chk("R9", "settled after 3 ticks", settled, 1);

    // R12 lock dependence and power-down
    lock = 1'b0;
    #1;
    chk("R12", "settled without lock", settled, 0);
    lock = 1'b1;
    #1;
    chk("R12", "settled with lock", settled, 1);
    @(negedge clk);
    pd_n = 1'b0;
    cycles(4);
    chk("R2", "force_low", force_low, 1);
    chk("R12", "settled in power-down", settled, 0);

    done = 1'b1;
    finish_run();
  end

endmodule